// File: doc/BRIEF.md
# Dual Timer with Interrupt Controller

This block holds two 16-bit down-counters and a seven-source interrupt flag and mask pair. The combined interrupt request is active low. A host reaches the block through a byte-wide register bus with a 4-bit address. A bus cycle is one clock with `sel` high, and `wr_en` picks write or read. Read data is combinational from `addr`. Some register accesses also act on the timers and flags: they arm a timer or clear a flag at the clock edge that ends the access.

The first timer has a 16-bit reload value held apart from the counter. It can stop flagging after its first expiry or reload and run freely. While it runs freely it can also toggle or pulse the output pin `tmr_pin`. The second timer always flags once per start. It either counts clock cycles or counts rising edges on `cnt_pin`. Five more flag sources arrive as one-cycle strobes on `ev_in`.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset the enable register (0xE) reads 0x80, the flag register (0xD) reads 0x00, the mode register (0xB) reads 0x00, `irq_n` is 1 and `tmr_pin` is 1.
- R2: A write to 0x4 or 0x6 stores the low reload byte of timer 1. A write to 0x7 stores the high reload byte. A write to 0x5 stores the high reload byte, loads the counter with {written byte, low reload byte}, clears flag bit 6 and starts timer 1. The counter reads at 0x4 (low) and 0x5 (high), and the reload value reads at 0x6 (low) and 0x7 (high).
- R3: Timer 1 decrements once per clock. When it is loaded with N, flag bit 6 sets on the (N+1)th clock edge after the load, which is the edge where the counter leaves zero.
- R4: In mode-register bits 7:6 = 00 (one-shot), only the first expiry after a start sets the flag. The counter then wraps through 0xFFFF and keeps counting.
- R5: With bits 7:6 = 01, the counter reloads from the reload value at each expiry and flags every L+1 cycles.
- R6: Bits 7:6 = 10 toggle `tmr_pin` at each expiry, and 11 drive it low for exactly one cycle after each expiry. Both modes run freely like 01. With bit 7 = 0, `tmr_pin` stays 1.
- R7: Timer 2 takes its low byte from a write to 0x8. A write to 0x9 loads the counter, clears flag bit 5 and starts it. With mode bit 5 = 0 it counts clocks and sets flag bit 5 once, on the (N+1)th step.
- R8: With mode bit 5 = 1, timer 2 steps only on rising edges of `cnt_pin`. A level held high counts as one step.
- R9: A read of 0x4 clears flag bit 6 and a read of 0x8 clears flag bit 5. A read of 0x5 or 0x9 leaves the flags unchanged.
- R10: Flag bits 6 and 5 belong to timers 1 and 2. Bits 4..0 are set by `ev_in[4]`..`ev_in[0]` at the edge where the strobe is high.
- R11: Writing the flag register clears each flag whose data bit is 1 and leaves the flags written with 0.
- R12: A write to the enable register with data bit 7 = 1 sets every enable bit written as 1. With bit 7 = 0 it clears them. Bit 7 of the enable register always reads 1.
- R13: Flag-register bit 7 reads 1 and `irq_n` is 0 exactly when some flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Bus access in this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not selected |
| cnt_pin | input | 1 | Pulse input for timer 2 |
| ev_in | input | 5 | External event strobes for flag bits 4..0 |
| tmr_pin | output | 1 | Timer 1 output pin |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The case hardest to reach from the ports is the continuous timer 1 with its output pin. There the cycle of each expiry matters, and the pin level depends on every earlier expiry. The stimulus first pushes the counter far from zero with a high-byte write in one-shot mode. Only then does it select the pin mode and load a short reload value. After that, each expiry edge can be counted from the arming write alone. The held-high `cnt_pin` case is reached by keeping the line up across several cycles and reading the counter back between steps.

// File: rtl/dual_timer_irq.sv
module dual_timer_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cnt_pin,
  input  logic [4:0] ev_in,
  output logic       tmr_pin,
  output logic       irq_n
);
  localparam logic [3:0] A_T1L = 4'h4, A_T1H = 4'h5, A_R1L = 4'h6, A_R1H = 4'h7;
  localparam logic [3:0] A_T2L = 4'h8, A_T2H = 4'h9, A_MODE = 4'hB;
  localparam logic [3:0] A_FLG = 4'hD, A_ENA = 4'hE;

  logic [15:0] t1_cnt, t1_rel, t2_cnt;
  logic [7:0]  t2_lo, mode;
  logic [6:0]  ifr, ier;
  logic        t1_arm, t2_arm, pin_q, cnt_prev;

  wire wr = sel & wr_en;
  wire rd = sel & ~wr_en;
  wire t1_ld = wr && addr == A_T1H;
  wire t2_ld = wr && addr == A_T2H;
  wire t1_free = |mode[7:6];
  wire t1_ev = (t1_cnt == 16'd0) && !t1_ld;
  wire t1_hit = t1_ev && (t1_arm || t1_free);
  wire t2_step = mode[5] ? (cnt_pin & ~cnt_prev) : 1'b1;
  wire t2_ev = (t2_cnt == 16'd0) && t2_step && !t2_ld;
  wire t2_hit = t2_ev && t2_arm;
  wire irq_any = |(ifr & ier);

  wire [6:0] clr = ((wr && addr == A_FLG) ? wdata[6:0] : 7'd0)
                 | {(rd && addr == A_T1L) || t1_ld, (rd && addr == A_T2L) || t2_ld, 5'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_cnt <= '0;
      t1_rel <= '0;
      t1_arm <= 1'b0;
    end else begin
      if (wr && (addr == A_T1L || addr == A_R1L)) t1_rel[7:0] <= wdata;
      if (wr && (addr == A_T1H || addr == A_R1H)) t1_rel[15:8] <= wdata;
      if (t1_ld) t1_cnt <= {wdata, t1_rel[7:0]};
      else if (t1_ev && t1_free) t1_cnt <= t1_rel;
      else t1_cnt <= t1_cnt - 16'd1;
      if (t1_ld) t1_arm <= 1'b1;
      else if (t1_ev) t1_arm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else begin
      case (mode[7:6])
        2'b10:   if (t1_hit) pin_q <= ~pin_q;
        2'b11:   pin_q <= ~t1_hit;
        default: pin_q <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t2_cnt   <= '0;
      t2_lo    <= '0;
      t2_arm   <= 1'b0;
      cnt_prev <= 1'b0;
    end else begin
      cnt_prev <= cnt_pin;
      if (wr && addr == A_T2L) t2_lo <= wdata;
      if (t2_ld) t2_cnt <= {wdata, t2_lo};
      else if (t2_step) t2_cnt <= t2_cnt - 16'd1;
      if (t2_ld) t2_arm <= 1'b1;
      else if (t2_ev) t2_arm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifr  <= '0;
      ier  <= '0;
      mode <= '0;
    end else begin
      ifr <= (ifr & ~clr) | {t1_hit, t2_hit, ev_in};
      if (wr && addr == A_MODE) mode <= wdata;
      if (wr && addr == A_ENA) ier <= wdata[7] ? (ier | wdata[6:0]) : (ier & ~wdata[6:0]);
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (sel) begin
      case (addr)
        A_T1L:  rdata = t1_cnt[7:0];
        A_T1H:  rdata = t1_cnt[15:8];
        A_R1L:  rdata = t1_rel[7:0];
        A_R1H:  rdata = t1_rel[15:8];
        A_T2L:  rdata = t2_cnt[7:0];
        A_T2H:  rdata = t2_cnt[15:8];
        A_MODE: rdata = mode;
        A_FLG:  rdata = {irq_any, ifr};
        A_ENA:  rdata = {1'b1, ier};
        default: rdata = 8'h00;
      endcase
    end
  end

  assign tmr_pin = pin_q;
  assign irq_n = ~irq_any;
endmodule

// File: rtl/dual_timer_irq_chk.sv
module dual_timer_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [7:0]  wdata,
  input logic [4:0]  ev_in,
  input logic [6:0]  ifr,
  input logic [6:0]  ier,
  input logic [15:0] t1_cnt
);
  p_ena_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == 4'hE && wdata[7]) |=> ((ier & $past(wdata[6:0])) == $past(wdata[6:0])));

  p_ena_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == 4'hE && !wdata[7]) |=> ((ier & $past(wdata[6:0])) == 7'd0));

  p_ev_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_in) |=> ((ifr[4:0] & $past(ev_in)) == $past(ev_in)));

  p_t1_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == 4'h5) |=> (t1_cnt[15:8] == $past(wdata) && !ifr[6]));

  p_flag_wclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == 4'hD && ev_in == 5'd0) |=> ((ifr[4:0] & $past(wdata[4:0])) == 5'd0));
endmodule

bind dual_timer_irq dual_timer_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ev_in(ev_in), .ifr(ifr), .ier(ier), .t1_cnt(t1_cnt)
);

// File: tb/dual_timer_irq_tb.sv
module dual_timer_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr_en = 1'b0, cnt_pin = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [4:0] ev_in = '0;
  logic [7:0] rdata;
  logic tmr_pin, irq_n;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_irq u_dut (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_pin(cnt_pin), .ev_in(ev_in), .tmr_pin(tmr_pin), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    sel = 1'b1; wr_en = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    sel = 1'b1; wr_en = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic pulse();
    cnt_pin = 1'b1; tick(1);
    cnt_pin = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(4'hE, v); chk("R1 enable reset", v, 8'h80);
    peek(4'hD, v); chk("R1 flag reset", v, 8'h00);
    peek(4'hB, v); chk("R1 mode reset", v, 8'h00);
    chk("R1 irq_n reset", {7'd0, irq_n}, 8'd1);
    chk("R1 pin reset", {7'd0, tmr_pin}, 8'd1);
  endtask

  task automatic t_t1_oneshot();
    logic [7:0] v;
    wr(4'h4, 8'd5);
    peek(4'h6, v); chk("R2 reload low", v, 8'd5);
    wr(4'h5, 8'h00);
    peek(4'h4, v); chk("R2 counter low", v, 8'd5);
    peek(4'h5, v); chk("R2 counter high", v, 8'd0);
    peek(4'h7, v); chk("R2 reload high", v, 8'd0);
    tick(5); peek(4'hD, v); chk("R3 no flag at zero", v & 8'h40, 8'h00);
    tick(1); peek(4'hD, v); chk("R3 flag N+1", v & 8'h40, 8'h40);
    rd(4'h5, v); peek(4'hD, v); chk("R9 high read keeps", v & 8'h40, 8'h40);
    rd(4'h4, v); peek(4'hD, v); chk("R9 low read clears", v & 8'h40, 8'h00);
    tick(20); peek(4'hD, v); chk("R4 no refire", v & 8'h40, 8'h00);
    peek(4'h5, v); chk("R4 wrapped", v, 8'hFF);
  endtask

  task automatic t_t1_free();
    logic [7:0] v;
    wr(4'hB, 8'h40);
    wr(4'h6, 8'd3);
    wr(4'h5, 8'h00);
    tick(3); peek(4'hD, v); chk("R5 first early", v & 8'h40, 8'h00);
    tick(1); peek(4'hD, v); chk("R5 first", v & 8'h40, 8'h40);
    wr(4'hD, 8'h40);
    tick(2); peek(4'hD, v); chk("R5 second early", v & 8'h40, 8'h00);
    tick(1); peek(4'hD, v); chk("R5 second", v & 8'h40, 8'h40);
    wr(4'hB, 8'h00);
    wr(4'h5, 8'hFF);
    wr(4'hD, 8'h40);
  endtask

  task automatic t_t1_pin();
    logic [7:0] v;
    chk("R6 pin idle", {7'd0, tmr_pin}, 8'd1);
    wr(4'hB, 8'h80);
    wr(4'h6, 8'd3);
    wr(4'h5, 8'h00);
    tick(3); chk("R6 toggle before", {7'd0, tmr_pin}, 8'd1);
    tick(1); chk("R6 toggle 1", {7'd0, tmr_pin}, 8'd0);
    tick(3); chk("R6 toggle hold", {7'd0, tmr_pin}, 8'd0);
    tick(1); chk("R6 toggle 2", {7'd0, tmr_pin}, 8'd1);
    wr(4'hB, 8'hC0);
    wr(4'h5, 8'h00);
    tick(3); chk("R6 pulse before", {7'd0, tmr_pin}, 8'd1);
    tick(1); chk("R6 pulse low", {7'd0, tmr_pin}, 8'd0);
    tick(1); chk("R6 pulse end", {7'd0, tmr_pin}, 8'd1);
    wr(4'hB, 8'h00);
    tick(4); chk("R6 pin off mode", {7'd0, tmr_pin}, 8'd1);
    peek(4'hB, v); chk("R6 mode back", v, 8'h00);
  endtask

  task automatic t_t2_clock();
    logic [7:0] v;
    wr(4'h8, 8'd4);
    wr(4'h9, 8'h00);
    peek(4'h8, v); chk("R7 counter load", v, 8'd4);
    tick(4); peek(4'hD, v); chk("R7 early", v & 8'h20, 8'h00);
    tick(1); peek(4'hD, v); chk("R7 flag", v & 8'h20, 8'h20);
    rd(4'h9, v); peek(4'hD, v); chk("R9 t2 high read keeps", v & 8'h20, 8'h20);
    rd(4'h8, v); peek(4'hD, v); chk("R9 t2 low read clears", v & 8'h20, 8'h00);
    tick(10); peek(4'hD, v); chk("R7 one-shot", v & 8'h20, 8'h00);
  endtask

  task automatic t_t2_pulse();
    logic [7:0] v;
    wr(4'hB, 8'h20);
    wr(4'h8, 8'd2);
    wr(4'h9, 8'h00);
    tick(5); peek(4'h8, v); chk("R8 idle no count", v, 8'd2);
    pulse(); peek(4'h8, v); chk("R8 one step", v, 8'd1);
    cnt_pin = 1'b1; tick(4); cnt_pin = 1'b0; tick(1);
    peek(4'h8, v); chk("R8 held high one step", v, 8'd0);
    peek(4'hD, v); chk("R8 no flag yet", v & 8'h20, 8'h00);
    pulse(); peek(4'hD, v); chk("R8 flag", v & 8'h20, 8'h20);
    wr(4'hB, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] v;
    wr(4'hD, 8'h7F);
    ev_in = 5'b10010; tick(1); ev_in = 5'd0;
    peek(4'hD, v); chk("R10 strobes", v & 8'h1F, 8'h12);
    ev_in = 5'b11111; tick(1); ev_in = 5'd0;
    wr(4'hD, 8'h05);
    peek(4'hD, v); chk("R11 selective clear", v & 8'h1F, 8'h1A);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    wr(4'hE, 8'h83); peek(4'hE, v); chk("R12 set", v, 8'h83);
    wr(4'hE, 8'h01); peek(4'hE, v); chk("R12 clear", v, 8'h82);
    wr(4'hE, 8'h7F); peek(4'hE, v); chk("R12 clear all", v, 8'h80);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    chk("R13 masked irq", {7'd0, irq_n}, 8'd1);
    peek(4'hD, v); chk("R13 masked bit7", v & 8'h80, 8'h00);
    wr(4'hE, 8'h82);
    chk("R13 irq active", {7'd0, irq_n}, 8'd0);
    peek(4'hD, v); chk("R13 bit7 set", v & 8'h80, 8'h80);
    wr(4'hD, 8'h02);
    chk("R13 irq released", {7'd0, irq_n}, 8'd1);
    peek(4'hD, v); chk("R13 bit7 clear", v & 8'h9F, 8'h18);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_t1_oneshot();
    t_t1_free();
    t_t1_pin();
    t_t2_clock();
    t_t2_pulse();
    t_events();
    t_enable();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule